// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

The sequencer takes one maintenance request covering an arbitrary byte range and turns it into a train of per-line command writes toward a cache control unit. A request consists of a physical address, a virtual address, a byte length and an operation code. The block floors the range to cache-line boundaries and counts the lines that the half-open interval touches. It then writes one line command per cycle, and finishes with a one-cycle done pulse.

A build-time parameter selects one of two addressing schemes. In the packed scheme, five virtual page-number bits ride in the low bits of each physical line address. In the split scheme, a separate tag port carries the physical address and the line port carries the virtual address. When the request is exactly one aligned page, the tag is written a single time. Flush-and-invalidate requests are bracketed by writes of the control unit's invalidate-mode bit. Any request that includes a write-back holds off completion until the unit's flush-busy status clears.

Top module: `cache_range_seq`

## Requirements
- R1: Operation codes are 1 invalidate, 2 write-back, 3 write-back-and-invalidate, 4 instruction invalidate. Codes 1 and 3 issue line kind 0 (data invalidate), code 2 issues kind 1 (data write-back), and code 4 issues kind 2 (instruction invalidate).
- R2: The line count equals ceil((length + paddr mod LINE_BYTES) / LINE_BYTES), and the first line address is the physical address floored to a line boundary.
- R3: The end of the range is exclusive: exactly the computed number of line commands is written, one per cycle, and never one for a line at or past start+length.
- R4: In packed mode (TAG_MODE=0), line k writes floor(paddr)+k*LINE_BYTES OR'ed with vaddr bits [17:13] placed in bits [4:0]. The tag port stays silent.
- R5: In split mode (TAG_MODE=1), line k writes floor(paddr)+k*LINE_BYTES on the tag port and floor(vaddr)+k*LINE_BYTES on the line port, both in the same cycle.
- R6: In split mode, a request whose length is exactly one page (8192 bytes) and whose physical address is page-aligned writes the tag once, with the physical address, in the cycle before the first line command, and writes no further tags. A page-length request that is not page-aligned follows R5.
- R7: For code 3, a control write with invalidate-mode 1 precedes the first line command, and a control write with invalidate-mode 0 follows the flush wait and precedes done. Other codes make no control write.
- R8: For codes 2 and 3, done is not raised in a cycle that follows an edge at which flush_busy was high. Done comes only after flush_busy has been seen low following the last line command.
- R9: A length of zero, or a code outside 1..4, completes with a done pulse and no tag, line or control write.
- R10: Busy is high from the cycle after a start is accepted through the done cycle, and low afterwards. Done lasts one cycle. A start while busy is ignored and produces no extra writes or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_op | input | 3 | Operation code (1..4) |
| req_paddr | input | 32 | Physical start address |
| req_vaddr | input | 32 | Virtual start address |
| req_len | input | 32 | Byte length |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Line command write strobe |
| cmd_kind | output | 2 | Line command kind (0 data inv, 1 data write-back, 2 instr inv) |
| cmd_data | output | 32 | Line command address word |
| tag_valid | output | 1 | Physical tag write strobe (split mode) |
| tag_data | output | 32 | Physical tag word |
| ctrl_wr_valid | output | 1 | Control register write strobe |
| ctrl_inv_mode | output | 1 | Invalidate-mode value written (1 = write back before discard) |
| flush_busy | input | 1 | Control unit flush in progress |

## Verification
The bench aims at the range edges. It uses an offset range that ends exactly on a line boundary, and then the same range one byte longer. A design with an inclusive end or a floor instead of a ceiling writes one line too many or too few. It issues page-length requests both on and off page alignment, where a design that tests only the length writes a single tag for a misaligned page. A flush responder holds flush_busy for several cycles, which exposes a design that reports completion early or clears the invalidate mode before the wait. A second start during a transfer catches a design that re-latches the request.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

    localparam int ADDR_W = 32;
    localparam int VBITS  = 5;

    localparam logic [2:0] OP_INV    = 3'd1;
    localparam logic [2:0] OP_WB     = 3'd2;
    localparam logic [2:0] OP_WBINV  = 3'd3;
    localparam logic [2:0] OP_ICINV  = 3'd4;

    typedef enum logic [1:0] {
        CK_DC_INV = 2'd0,
        CK_DC_WB  = 2'd1,
        CK_IC_INV = 2'd2
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_MODE_SET, S_TAG, S_LOOP, S_WAIT, S_MODE_CLR, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] va;
    } addr_pair_t;

    function automatic cmd_kind_e kind_of(input logic [2:0] op);
        if (op == OP_ICINV) return CK_IC_INV;
        if (op[0])          return CK_DC_INV;
        return CK_DC_WB;
    endfunction

    function automatic logic op_legal(input logic [2:0] op);
        return (op >= OP_INV) && (op <= OP_ICINV);
    endfunction

    function automatic logic op_flushes(input logic [2:0] op);
        return (op == OP_WB) || (op == OP_WBINV);
    endfunction

endpackage

// File: rtl/cmseq_range.sv
module cmseq_range
    import cmseq_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 8192,
    localparam int LB    = $clog2(LINE_BYTES),
    localparam int PB    = $clog2(PAGE_BYTES),
    localparam int CNT_W = ADDR_W + 2 - LB
) (
    input  logic [ADDR_W-1:0] pa,
    input  logic [ADDR_W-1:0] va,
    input  logic [ADDR_W-1:0] len,
    output addr_pair_t        aligned,
    output logic [CNT_W-1:0]  lines,
    output logic              full_page,
    output logic              empty
);

    logic [ADDR_W:0]   adj_len;
    logic [ADDR_W+1:0] rounded;
    logic              unused_va_lo;

    // Offset within the first line widens the span before rounding up.
    assign adj_len = {1'b0, len} + {{(ADDR_W+1-LB){1'b0}}, pa[LB-1:0]};
    assign rounded = {1'b0, adj_len} + (ADDR_W+2)'(LINE_BYTES - 1);
    assign lines   = rounded[ADDR_W+1:LB];

    assign aligned.pa = {pa[ADDR_W-1:LB], {LB{1'b0}}};
    assign aligned.va = {va[ADDR_W-1:LB], {LB{1'b0}}};

    assign full_page = (len == ADDR_W'(PAGE_BYTES)) && (pa[PB-1:0] == '0);
    assign empty     = (len == '0);

    assign unused_va_lo = ^va[LB-1:0];

endmodule

// File: rtl/cmseq_fmt.sv
module cmseq_fmt
    import cmseq_pkg::*;
#(
    parameter bit TAG_MODE = 1'b0
) (
    input  addr_pair_t        cur,
    input  logic [VBITS-1:0]  vbits,
    output logic [ADDR_W-1:0] cmd_word,
    output logic [ADDR_W-1:0] tag_word
);

    generate
        if (TAG_MODE) begin : g_split
            logic [VBITS-1:0] unused_vbits;
            assign unused_vbits = vbits;
            assign cmd_word = cur.va;
            assign tag_word = cur.pa;
        end else begin : g_packed
            logic unused_va;
            assign unused_va = ^cur.va;
            // Line offset bits are free once the address is line-aligned.
            assign cmd_word = cur.pa | {{(ADDR_W-VBITS){1'b0}}, vbits};
            assign tag_word = '0;
        end
    endgenerate

endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
    import cmseq_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 8192,
    parameter bit TAG_MODE   = 1'b0,
    localparam int PB    = $clog2(PAGE_BYTES),
    localparam int CNT_W = ADDR_W + 2 - $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_len,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_data,
    output logic              tag_valid,
    output logic [ADDR_W-1:0] tag_data,
    output logic              ctrl_wr_valid,
    output logic              ctrl_inv_mode,
    input  logic              flush_busy
);

    seq_state_e        state_q, state_d;
    logic [2:0]        op_q;
    addr_pair_t        cur_q;
    logic [CNT_W-1:0]  remain_q;
    logic              full_q;
    logic [VBITS-1:0]  vbits_q;

    addr_pair_t        rng_aligned;
    logic [CNT_W-1:0]  rng_lines;
    logic              rng_full, rng_empty;
    logic              accept, split_full;

    cmseq_range #(.LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_range (
        .pa(req_paddr), .va(req_vaddr), .len(req_len),
        .aligned(rng_aligned), .lines(rng_lines),
        .full_page(rng_full), .empty(rng_empty)
    );

    cmseq_fmt #(.TAG_MODE(TAG_MODE)) u_fmt (
        .cur(cur_q), .vbits(vbits_q),
        .cmd_word(cmd_data), .tag_word(tag_data)
    );

    assign accept     = (state_q == S_IDLE) && req_start;
    assign split_full = TAG_MODE && full_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_start) begin
                if (!op_legal(req_op) || rng_empty) state_d = S_DONE;
                else if (req_op == OP_WBINV)        state_d = S_MODE_SET;
                else if (TAG_MODE && rng_full)      state_d = S_TAG;
                else                                state_d = S_LOOP;
            end
            S_MODE_SET: state_d = split_full ? S_TAG : S_LOOP;
            S_TAG:      state_d = S_LOOP;
            S_LOOP: if (remain_q == CNT_W'(1))
                state_d = op_flushes(op_q) ? S_WAIT : S_DONE;
            S_WAIT: if (!flush_busy)
                state_d = (op_q == OP_WBINV) ? S_MODE_CLR : S_DONE;
            S_MODE_CLR: state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            op_q     <= '0;
            cur_q    <= '0;
            remain_q <= '0;
            full_q   <= 1'b0;
            vbits_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q     <= req_op;
                cur_q    <= rng_aligned;
                remain_q <= rng_lines;
                full_q   <= rng_full;
                vbits_q  <= req_vaddr[PB+VBITS-1:PB];
            end else if (state_q == S_LOOP) begin
                cur_q.pa <= cur_q.pa + ADDR_W'(LINE_BYTES);
                cur_q.va <= cur_q.va + ADDR_W'(LINE_BYTES);
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign busy          = (state_q != S_IDLE);
    assign done          = (state_q == S_DONE);
    assign cmd_valid     = (state_q == S_LOOP);
    assign cmd_kind      = kind_of(op_q);
    assign tag_valid     = (state_q == S_TAG) ||
                           (TAG_MODE && (state_q == S_LOOP) && !full_q);
    assign ctrl_wr_valid = (state_q == S_MODE_SET) || (state_q == S_MODE_CLR);
    assign ctrl_inv_mode = (state_q == S_MODE_SET);

    AST_NO_LINE_PAST_END: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> remain_q != '0); // R3
    AST_TAG_SINGLE_FULL_PAGE: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && full_q) |=> !tag_valid); // R6
    AST_MODE_ONLY_WBINV: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr_valid |-> op_q == OP_WBINV); // R7
    AST_WAIT_WHILE_FLUSHING: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && flush_busy) |=> state_q == S_WAIT); // R8
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R10
    AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(op_q)); // R10

endmodule

// File: tb/cache_range_seq_bench.sv
`timescale 1ns/1ps
module cache_range_seq_bench;

    localparam int LINE      = 64;
    localparam int PAGE      = 8192;
    localparam int FLUSH_LAT = 6;
    localparam int LOGN      = 320;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        req_start = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_paddr = '0, req_vaddr = '0, req_len = '0;

    logic        busy_w [2];
    logic        done_w [2];
    logic        cmdv_w [2];
    logic [1:0]  kind_w [2];
    logic [31:0] cmdd_w [2];
    logic        tagv_w [2];
    logic [31:0] tagd_w [2];
    logic        ctlv_w [2];
    logic        ctlm_w [2];
    logic        fbusy  [2];

    cache_range_seq #(.TAG_MODE(1'b0)) u_cache_range_seq (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_paddr(req_paddr), .req_vaddr(req_vaddr), .req_len(req_len),
        .busy(busy_w[0]), .done(done_w[0]), .cmd_valid(cmdv_w[0]),
        .cmd_kind(kind_w[0]), .cmd_data(cmdd_w[0]), .tag_valid(tagv_w[0]),
        .tag_data(tagd_w[0]), .ctrl_wr_valid(ctlv_w[0]),
        .ctrl_inv_mode(ctlm_w[0]), .flush_busy(fbusy[0])
    );

    cache_range_seq #(.TAG_MODE(1'b1)) u_cache_range_seq_split (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_paddr(req_paddr), .req_vaddr(req_vaddr), .req_len(req_len),
        .busy(busy_w[1]), .done(done_w[1]), .cmd_valid(cmdv_w[1]),
        .cmd_kind(kind_w[1]), .cmd_data(cmdd_w[1]), .tag_valid(tagv_w[1]),
        .tag_data(tagd_w[1]), .ctrl_wr_valid(ctlv_w[1]),
        .ctrl_inv_mode(ctlm_w[1]), .flush_busy(fbusy[1])
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycle    = 0;

    // Event log: type 0 line command, 1 tag, 2 control
    int          log_n     [2];
    logic [1:0]  log_type  [2][LOGN];
    logic [31:0] log_data  [2][LOGN];
    logic [1:0]  log_kind  [2][LOGN];
    int          done_cnt  [2];
    int          early_done[2];
    int          last_cmd  [2];
    int          done_cyc  [2];
    int          hold      [2];

    logic [1:0]  exp_type [LOGN];
    logic [31:0] exp_data [LOGN];
    logic [1:0]  exp_kind [LOGN];
    int          exp_n;

    initial begin
        for (int m = 0; m < 2; m++) begin
            fbusy[m] = 1'b0; hold[m] = 0; log_n[m] = 0; done_cnt[m] = 0;
            early_done[m] = 0; last_cmd[m] = 0; done_cyc[m] = 0;
        end
    end

    task automatic push(input int m, input logic [1:0] t, input logic [31:0] d,
                        input logic [1:0] k);
        if (log_n[m] < LOGN) begin
            log_type[m][log_n[m]] = t;
            log_data[m][log_n[m]] = d;
            log_kind[m][log_n[m]] = k;
        end
        log_n[m]++;
    endtask

    // Monitor and flush-status responder, both away from the active edge
    always @(negedge clk) begin
        cycle++;
        for (int m = 0; m < 2; m++) begin
            if (tagv_w[m]) push(m, 2'd1, tagd_w[m], 2'd0);
            if (cmdv_w[m]) begin
                push(m, 2'd0, cmdd_w[m], kind_w[m]);
                last_cmd[m] = cycle;
            end
            if (ctlv_w[m]) push(m, 2'd2, {31'd0, ctlm_w[m]}, 2'd0);
            if (done_w[m]) begin
                done_cnt[m]++;
                done_cyc[m] = cycle;
                if (fbusy[m]) early_done[m]++;
            end
            if (cmdv_w[m] && kind_w[m] != 2'd2) hold[m] = FLUSH_LAT;
            else if (hold[m] > 0)               hold[m] = hold[m] - 1;
            fbusy[m] = (hold[m] != 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_kind_of(input logic [2:0] op);
        if (op == 3'd4) return 2'd2;
        if (op[0])      return 2'd0;
        return 2'd1;
    endfunction

    task automatic build_expect(input int m, input logic [2:0] op, input logic [31:0] pa,
                                input logic [31:0] va, input logic [31:0] len);
        logic [31:0] pa_al, va_al, lines;
        logic        full;
        pa_al = pa & ~32'(LINE - 1);
        va_al = va & ~32'(LINE - 1);
        lines = (len + (pa & 32'(LINE - 1)) + 32'(LINE - 1)) / LINE;
        full  = (m == 1) && (len == PAGE) && (pa % PAGE == 0);
        exp_n = 0;
        if (len == 0 || op < 3'd1 || op > 3'd4) return;
        if (op == 3'd3) begin
            exp_type[exp_n] = 2'd2; exp_data[exp_n] = 32'd1; exp_kind[exp_n] = 2'd0; exp_n++;
        end
        if (full) begin
            exp_type[exp_n] = 2'd1; exp_data[exp_n] = pa; exp_kind[exp_n] = 2'd0; exp_n++;
        end
        for (int k = 0; k < int'(lines); k++) begin
            if (m == 1 && !full) begin
                exp_type[exp_n] = 2'd1; exp_data[exp_n] = pa_al + 32'(k * LINE);
                exp_kind[exp_n] = 2'd0; exp_n++;
            end
            exp_type[exp_n] = 2'd0;
            exp_data[exp_n] = (m == 1) ? va_al + 32'(k * LINE)
                                       : (pa_al + 32'(k * LINE)) | {27'd0, va[17:13]};
            exp_kind[exp_n] = exp_kind_of(op);
            exp_n++;
        end
        if (op == 3'd3) begin
            exp_type[exp_n] = 2'd2; exp_data[exp_n] = 32'd0; exp_kind[exp_n] = 2'd0; exp_n++;
        end
    endtask

    task automatic compare_log(input int m, input string req);
        int bad;
        bad = -1;
        check(log_n[m] == exp_n, req, $sformatf("dut%0d event count", m),
              32'(log_n[m]), 32'(exp_n));
        for (int i = 0; i < exp_n && i < log_n[m] && i < LOGN; i++) begin
            if (bad < 0 && (log_type[m][i] != exp_type[i] || log_data[m][i] != exp_data[i]
                            || log_kind[m][i] != exp_kind[i]))
                bad = i;
        end
        if (bad >= 0)
            check(1'b0, req, $sformatf("dut%0d event %0d type%0d/kind%0d vs type%0d/kind%0d",
                  m, bad, log_type[m][bad], log_kind[m][bad], exp_type[bad], exp_kind[bad]),
                  log_data[m][bad], exp_data[bad]);
        else
            check(1'b1, req, "sequence", 32'd0, 32'd0);
    endtask

    task automatic run_req(input logic [2:0] op, input logic [31:0] pa, input logic [31:0] va,
                           input logic [31:0] len, input bit intrude, input string req);
        int guard;
        for (int m = 0; m < 2; m++) begin
            log_n[m] = 0; done_cnt[m] = 0; early_done[m] = 0;
        end
        @(negedge clk);
        req_start = 1'b1; req_op = op; req_paddr = pa; req_vaddr = va; req_len = len;
        @(negedge clk);
        req_start = 1'b0;
        for (int m = 0; m < 2; m++)
            check(busy_w[m] == 1'b1, "R10", $sformatf("dut%0d busy after start", m),
                  32'(busy_w[m]), 32'd1);
        if (intrude) begin
            req_start = 1'b1; req_op = 3'd2; req_paddr = 32'h5555_0000; req_len = 32'd640;
            @(negedge clk);
            req_start = 1'b0;
        end
        guard = 0;
        while ((done_cnt[0] == 0 || done_cnt[1] == 0) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check(busy_w[m] == 1'b0, "R10", $sformatf("dut%0d idle after done", m),
                  32'(busy_w[m]), 32'd0);
            check(done_cnt[m] == 1, "R10", $sformatf("dut%0d single done pulse", m),
                  32'(done_cnt[m]), 32'd1);
            build_expect(m, op, pa, va, len);
            compare_log(m, req);
            if ((op == 3'd2 || op == 3'd3) && len != 0) begin
                check(early_done[m] == 0, "R8", $sformatf("dut%0d done during flush", m),
                      32'(early_done[m]), 32'd0);
                check(done_cyc[m] - last_cmd[m] > FLUSH_LAT, "R8",
                      $sformatf("dut%0d cycles from last line to done", m),
                      32'(done_cyc[m] - last_cmd[m]), 32'(FLUSH_LAT + 1));
            end
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int m = 0; m < 2; m++) begin
            check(!busy_w[m] && !done_w[m], "R10", "reset idle", {31'd0, busy_w[m]}, 32'd0);
            check(!cmdv_w[m] && !tagv_w[m] && !ctlv_w[m], "R3", "reset no writes",
                  {31'd0, cmdv_w[m]}, 32'd0);
        end
    endtask

    // R1 R2 R4 R5: aligned three-line invalidate
    task automatic t_aligned_inv();
        run_req(3'd1, 32'h1000_0000, 32'h0002_6000, 32'd192, 1'b0, "R1/R2/R4/R5");
    endtask

    // R3: offset range ending exactly on a line boundary, then one byte more
    task automatic t_exclusive_end();
        run_req(3'd2, 32'h2000_0030, 32'h0003_4030, 32'h10, 1'b0, "R3 exact end");
        run_req(3'd2, 32'h2000_0030, 32'h0003_4030, 32'h11, 1'b0, "R3 one past");
        run_req(3'd2, 32'h2000_0030, 32'h0003_4030, 32'h50, 1'b0, "R2 unaligned");
    endtask

    // R7 R8: write-back-and-invalidate with mode bracket and flush wait
    task automatic t_wbinv();
        run_req(3'd3, 32'h4000_0104, 32'h0001_e104, 32'd100, 1'b0, "R7");
    endtask

    // R1: instruction invalidate, no flush wait
    task automatic t_icinv();
        run_req(3'd4, 32'h0800_0040, 32'h0000_a040, 32'd64, 1'b0, "R1 icache");
    endtask

    // R6: aligned page writes one tag; misaligned page writes per-line tags
    task automatic t_page();
        run_req(3'd1, 32'h3000_2000, 32'h0005_2000, 32'd8192, 1'b0, "R6 aligned page");
        run_req(3'd2, 32'h3000_2040, 32'h0005_2040, 32'd8192, 1'b0, "R6 offset page");
    endtask

    // R9: empty length and illegal code
    task automatic t_nothing();
        run_req(3'd2, 32'h1234_5678, 32'h0000_0000, 32'd0, 1'b0, "R9 zero length");
        run_req(3'd5, 32'h1234_5600, 32'h0000_0000, 32'd128, 1'b0, "R9 illegal op");
        run_req(3'd0, 32'h1234_5600, 32'h0000_0000, 32'd128, 1'b0, "R9 op zero");
    endtask

    // R10: start while busy is ignored
    task automatic t_start_busy();
        run_req(3'd3, 32'h6000_0000, 32'h0000_4000, 32'd256, 1'b1, "R10 start ignored");
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_aligned_inv();
        t_exclusive_end();
        t_wbinv();
        t_icinv();
        t_page();
        t_nothing();
        t_start_busy();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule